// File: doc/BRIEF.md
# Banked Word Memory with Selectable Bank Mapping

This block is a word-addressed storage array assembled from byte-wide storage modules. Each module has a chip select, a single write-enable line and a byte-wide data path. The modules are placed side by side in groups so that each group stores one full data word. Each group is a bank, and a word address picks exactly one bank for every access.

An elaboration-time parameter sets how an address is split. In high-order mapping, the most significant address bits name the bank, so each bank covers one contiguous part of the address space. In interleaved mapping, the least significant bits name the bank, so consecutive word addresses move from one bank to the next. In both mappings, a word always reads back from the address it was written to.

Requests enter on a valid/ready stream and carry an address, a write flag and write data. Only reads produce a response, and it comes back on a second valid/ready stream one cycle after the read is accepted. A single response register sits on the output. While a response is held back by a low `rsp_ready`, the block drops `req_ready`, so it accepts no new read or write. A request is accepted in any cycle where `req_valid` and `req_ready` are both high. A response is consumed in any cycle where `rsp_valid` and `rsp_ready` are both high. A plain one-hot output, `bank_sel`, shows which bank an accepted request reaches. The default widths give a small array. Setting `ADDR_W` to 16 gives 64K words in four banks, with 14 address bits at each byte module.

Top module: `banked_word_mem`

## Requirements
- R1: While reset is held and directly after it, `rsp_valid` is 0, `req_ready` is 1, and `bank_sel` is all zero when no request is offered.
- R2: A word written at an address reads back unchanged from that address, in both mapping modes.
- R3: A read accepted in cycle N makes `rsp_valid` high in cycle N+1, with the stored word on `rsp_rdata`.
- R4: `bank_sel` has exactly one bit set in a cycle where a request is accepted, and is all zero in every other cycle, including cycles where a request is offered but not accepted.
- R5: With interleaved mapping, an accepted request to address A sets `bank_sel` bit (A mod NUM_BANKS), so sequential addresses rotate through banks 0,1,2,3.
- R6: With high-order mapping, an accepted request to address A sets `bank_sel` bit (A >> (ADDR_W - log2 NUM_BANKS)), so each quarter of the address space uses one bank.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0, and `rsp_valid` and `rsp_rdata` hold their values into the next cycle.
- R8: An accepted write produces no response: `rsp_valid` is 0 in the cycle after it.
- R9: A write changes only the addressed word. Words held in other banks, and other words in the same bank, read back with their earlier values.
- R10: Byte lane k of a word (bits 8k+7:8k) is stored in the k-th byte module of the chosen bank, and lane 0 drives `rsp_rdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to store on a write |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | DATA_W | Word read |
| bank_sel | output | NUM_BANKS | One-hot bank reached by the accepted request |

## Verification
The bench runs an interleaved instance and a high-order instance side by side on the same stimulus. It walks through the whole address range and checks the bank each address reaches. A design with swapped mapping would show the wrong rotation, or a constant bank where the banks should rotate. It overwrites every word of one interleaved bank and then reads back every address. A design that wrote more than one bank, or that ignored part of the address inside the bank, would return stale or aliased words. It also holds a response back with `rsp_ready` low while offering a new request. A design without correct back-pressure would accept that request, lose the held data or change it, or raise `bank_sel` for a request it never took.

// File: rtl/banked_word_mem_pkg.sv
package banked_word_mem_pkg;

  typedef enum logic {
    MAP_HIGH_ORDER = 1'b0,
    MAP_INTERLEAVE = 1'b1
  } bank_map_e;

endpackage

// File: rtl/bwm_addr_split.sv
module bwm_addr_split
  import banked_word_mem_pkg::*;
#(
  parameter int        ADDR_W   = 8,
  parameter int        BANK_W   = 2,
  parameter bank_map_e MAP_MODE = MAP_INTERLEAVE,
  localparam int       LOC_W    = ADDR_W - BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank_idx,
  output logic [LOC_W-1:0]  loc
);

  generate
    if (MAP_MODE == MAP_INTERLEAVE) begin : g_low
      // bottom bits rotate the bank, upper bits index inside it
      assign bank_idx = addr[BANK_W-1:0];
      assign loc      = addr[ADDR_W-1:BANK_W];
    end else begin : g_high
      // top bits pick a contiguous region per bank
      assign bank_idx = addr[ADDR_W-1 -: BANK_W];
      assign loc      = addr[LOC_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/bwm_byte_store.sv
module bwm_byte_store #(
  parameter int LOC_W  = 6,
  parameter int BYTE_W = 8,
  localparam int DEPTH = 1 << LOC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [LOC_W-1:0]  loc,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);

  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (cs && we) begin
      cells[loc] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (cs && !we) begin
      dout <= cells[loc];
    end
  end

endmodule

// File: rtl/bwm_bank_slice.sv
module bwm_bank_slice #(
  parameter int LOC_W  = 6,
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [LOC_W-1:0]  loc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      // lane k holds bits [k*BYTE_W +: BYTE_W]; lane 0 is the low byte
      bwm_byte_store #(
        .LOC_W  (LOC_W),
        .BYTE_W (BYTE_W)
      ) u_byte (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .we    (we),
        .loc   (loc),
        .din   (wdata[k*BYTE_W +: BYTE_W]),
        .dout  (rdata[k*BYTE_W +: BYTE_W])
      );
    end
  endgenerate

endmodule

// File: rtl/banked_word_mem.sv
module banked_word_mem
  import banked_word_mem_pkg::*;
#(
  parameter int        ADDR_W    = 8,
  parameter int        BYTE_W    = 8,
  parameter int        LANES     = 4,
  parameter int        NUM_BANKS = 4,
  parameter bank_map_e MAP_MODE  = MAP_INTERLEAVE,
  localparam int       DATA_W    = BYTE_W * LANES,
  localparam int       BANK_W    = $clog2(NUM_BANKS),
  localparam int       LOC_W     = ADDR_W - BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_BANKS-1:0] bank_sel
);

  logic              fire;
  logic              rd_fire;
  logic [BANK_W-1:0] bank_idx;
  logic [BANK_W-1:0] bank_q;
  logic [LOC_W-1:0]  loc;
  logic [DATA_W-1:0] slice_rdata [NUM_BANKS];

  // a held response blocks the whole request side
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign rd_fire   = fire && !req_write;

  bwm_addr_split #(
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .MAP_MODE (MAP_MODE)
  ) u_split (
    .addr     (req_addr),
    .bank_idx (bank_idx),
    .loc      (loc)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_sel[b] = fire && (bank_idx == BANK_W'(b));

      bwm_bank_slice #(
        .LOC_W  (LOC_W),
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
      ) u_slice (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (bank_sel[b]),
        .we    (req_write),
        .loc   (loc),
        .wdata (req_wdata),
        .rdata (slice_rdata[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q    <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (rd_fire) begin
        bank_q <= bank_idx;
      end
      if (rd_fire) begin
        rsp_valid <= 1'b1;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // slice outputs only move on a selected read, which cannot happen while held
  assign rsp_rdata = slice_rdata[bank_q];

endmodule

// File: rtl/banked_word_mem_chk.sv
module banked_word_mem_chk
  import banked_word_mem_pkg::*;
#(
  parameter int        ADDR_W    = 8,
  parameter int        DATA_W    = 32,
  parameter int        NUM_BANKS = 4,
  parameter bank_map_e MAP_MODE  = MAP_INTERLEAVE,
  localparam int       BANK_W    = $clog2(NUM_BANKS),
  localparam bit       IS_LOW    = (MAP_MODE == MAP_INTERLEAVE)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic [NUM_BANKS-1:0] bank_sel
);

  logic acc;
  assign acc = req_valid && req_ready;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) acc |-> $onehot(bank_sel)); // R4
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !acc |-> bank_sel == '0); // R4
  AST_MAP_LOW: assert property (@(posedge clk) disable iff (!rst_n) (IS_LOW && acc) |-> bank_sel == (NUM_BANKS'(1) << req_addr[BANK_W-1:0])); // R5
  AST_MAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (!IS_LOW && acc) |-> bank_sel == (NUM_BANKS'(1) << req_addr[ADDR_W-1 -: BANK_W])); // R6
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (acc && !req_write) |=> rsp_valid); // R3
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (acc && req_write) |=> !rsp_valid); // R8
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |-> !req_ready); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R7

endmodule

bind banked_word_mem banked_word_mem_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_BANKS (NUM_BANKS),
  .MAP_MODE  (MAP_MODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .bank_sel  (bank_sel)
);

// File: tb/banked_word_mem_test.sv
`timescale 1ns/1ps
module banked_word_mem_test;
  import banked_word_mem_pkg::*;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NB     = 4;
  localparam int WORDS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_ready = 1'b1;

  logic              rdy_lo, rdy_hi, vld_lo, vld_hi;
  logic [DATA_W-1:0] dat_lo, dat_hi;
  logic [NB-1:0]     sel_lo, sel_hi;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] model [WORDS];
  logic [DATA_W-1:0] expq [$];

  always #4 clk = ~clk;

  banked_word_mem #(.ADDR_W(ADDR_W), .NUM_BANKS(NB), .MAP_MODE(MAP_INTERLEAVE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_lo),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(vld_lo), .rsp_ready(rsp_ready), .rsp_rdata(dat_lo), .bank_sel(sel_lo));

  banked_word_mem #(.ADDR_W(ADDR_W), .NUM_BANKS(NB), .MAP_MODE(MAP_HIGH_ORDER)) uut_hi (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_hi),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(vld_hi), .rsp_ready(rsp_ready), .rsp_rdata(dat_hi), .bank_sel(sel_hi));

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int a, input int seed);
    return (32'h9E37_79B9 * (a + 1)) ^ (32'h0101_0101 * seed) ^ {a[7:0], ~a[7:0], a[7:0], 8'h5A};
  endfunction

  // driver: one request per cycle; checks bank selection before the accepting edge
  task automatic send(input bit wr, input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(a); req_wdata = d;
    #1;
    while (!rdy_lo) begin @(negedge clk); #1; end
    chk(sel_lo == NB'(1 << (a % NB)), "R5 interleaved bank", 32'(sel_lo), 32'(1 << (a % NB)));
    chk(sel_hi == NB'(1 << (a / (WORDS / NB))), "R6 high-order bank", 32'(sel_hi),
        32'(1 << (a / (WORDS / NB))));
    chk(rdy_hi == rdy_lo, "R7 ready agreement", 32'(rdy_hi), 32'(rdy_lo));
    if (wr) model[a] = d;
    else expq.push_back(model[a]);
    @(posedge clk);
    #1 req_valid = 1'b0;
    if (wr) chk(!vld_lo && !vld_hi, "R8 no response after write", 32'(vld_lo | vld_hi), 32'h0);
  endtask

  // monitor: a handshake seen at a falling edge completes at the next rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(vld_lo == vld_hi, "R3 valid agreement", 32'(vld_lo), 32'(vld_hi));
      if (vld_lo && rsp_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R8 unexpected response", dat_lo, 32'h0);
        end else begin
          logic [DATA_W-1:0] e;
          e = expq.pop_front();
          chk(dat_lo == e, "R2 interleaved readback", dat_lo, e);
          chk(dat_hi == e, "R2 high-order readback", dat_hi, e);
          chk(dat_lo[7:0] == e[7:0], "R10 low byte lane", 32'(dat_lo[7:0]), 32'(e[7:0]));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] held;
    repeat (3) @(negedge clk);
    chk(!vld_lo && !vld_hi, "R1 valid low in reset", 32'(vld_lo | vld_hi), 32'h0);
    chk(sel_lo == '0 && sel_hi == '0, "R1 no bank in reset", 32'(sel_lo | sel_hi), 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_lo && rdy_hi, "R1 ready after reset", 32'(rdy_lo & rdy_hi), 32'h1);
    chk(!vld_lo, "R1 valid low after reset", 32'(vld_lo), 32'h0);

    // sequential writes across the whole range, bank rotation checked per address
    for (int a = 0; a < WORDS; a++) send(1'b1, a, pat(a, 1));
    for (int a = 0; a < WORDS; a++) send(1'b0, a, '0);

    // R9: overwrite every word of interleaved bank 2, then read all back
    for (int a = 2; a < WORDS; a += NB) send(1'b1, a, pat(a, 7));
    for (int a = WORDS - 1; a >= 0; a--) send(1'b0, a, '0);

    // R10: distinct byte values in each lane
    send(1'b1, 9, 32'hA4B3_C2D1);
    send(1'b0, 9, '0);

    // R7: hold a response and offer a new request against it
    @(posedge clk); #1 rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'd77; #1;
    expq.push_back(model[77]);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(vld_lo && vld_hi, "R3 response one cycle after read", 32'(vld_lo & vld_hi), 32'h1);
    chk(dat_lo == model[77], "R3 read data", dat_lo, model[77]);
    held = dat_lo;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd77; req_wdata = 32'hDEAD_BEEF; #1;
    for (int i = 0; i < 3; i++) begin
      chk(!rdy_lo && !rdy_hi, "R7 request blocked while held", 32'(rdy_lo | rdy_hi), 32'h0);
      chk(sel_lo == '0 && sel_hi == '0, "R4 no bank when not accepted", 32'(sel_lo | sel_hi), 32'h0);
      chk(vld_lo && dat_lo == held, "R7 held data stable", dat_lo, held);
      @(negedge clk); #1;
    end
    req_valid = 1'b0;
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    send(1'b0, 77, '0); // the blocked write must not have landed

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R3 all reads answered", 32'(expq.size()), 32'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule